// File: doc/BRIEF.md
# Codec Serial Frame Master

This block is the frame-owning end of a synchronous serial link to a voice codec. A bit-rate enable, one clock wide, marks each bit slot. The block counts these slots into frames and raises a one-slot frame-sync pulse at the start of every frame. In each frame it shifts one 16-bit word out and one 16-bit word in, most significant bit first, in the slots that follow the sync. With the default frame length of 256 slots, a 2.048 MHz bit rate gives an 8 kHz frame rate.

Two framing modes are supported. In plain mode, every frame carries a full 16-bit audio sample. In 15+1 mode, the audio sample keeps only its upper 15 bits. Bit 0 of the outgoing word becomes a request flag. When the flag is set, the following frame is a control frame that carries a codec register write in place of audio. After it, audio frames resume. A small request port supplies the register address and data. The request is sampled when an audio frame begins.

Top module: `codec_frame_master`

## Requirements
- R1: While reset is held, fs, dout, tx_take, cfg_ack, rx_valid and cfg_done are all 0.
- R2: fs is high for exactly one bit slot (slot 0) of every frame, and frames repeat every FRAME_LEN enabled bit slots. The first enabled slot after reset is slot 0.
- R3: A clock with bit_en low changes neither fs nor dout, and produces no pulse on tx_take, cfg_ack, rx_valid or cfg_done.
- R4: dout carries word bit 15 in slot 1, down to bit 0 in slot 16. dout is 0 in every other slot.
- R5: din is sampled at the end of slots 1 to 16, MSB first. After slot 16 of an audio frame, rx_valid pulses for one clock and rx_word holds the received word.
- R6: tx_take pulses for one clock as fs rises on every audio frame, marking the moment tx_word is captured.
- R7: In plain mode (ctl_mode=0), the full tx_word is sent, cfg_ack never pulses and no control frame occurs.
- R8: In 15+1 mode (ctl_mode=1), an audio frame sends {tx_word[15:1], flag}. The flag is 1 exactly when cfg_req is high with cfg_addr in 1..4 at frame start.
- R9: A frame whose flag is 1 is followed by one control frame. Its word has bits [15:13]=0, bit 12=0 (write), bits [11:8]=address and bits [7:0]=data. Audio frames follow after it.
- R10: A request with cfg_addr outside 1..4 is acknowledged but ignored: the flag is 0 and the next frame is an audio frame.
- R11: A control frame gives no tx_take and no rx_valid. cfg_done pulses for one clock after its slot 16.
- R12: In 15+1 mode, cfg_ack pulses together with tx_take when cfg_req is high at the start of an audio frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-clock bit-slot enable |
| ctl_mode | input | 1 | 0 = plain 16-bit frames, 1 = 15+1 mode |
| fs | output | 1 | Frame sync, high during slot 0 |
| dout | output | 1 | Serial data to the codec |
| din | input | 1 | Serial data from the codec |
| tx_word | input | 16 | Audio sample to send |
| tx_take | output | 1 | Pulse: tx_word captured |
| rx_word | output | 16 | Last received audio sample |
| rx_valid | output | 1 | Pulse: rx_word updated |
| cfg_req | input | 1 | Register-write request |
| cfg_addr | input | 4 | Register address (1..4 valid) |
| cfg_data | input | 8 | Register data |
| cfg_ack | output | 1 | Pulse: request taken |
| cfg_done | output | 1 | Pulse: control frame finished |

## Verification
Each result is due a fixed number of enabled bit slots after the enable that opens a frame. fs, tx_take and cfg_ack are seen at the clock that enters slot 0. Word bit k appears on dout at the clock that enters slot 16-k. rx_valid or cfg_done pulses at the clock that leaves slot 16. The bench keeps its own slot counter, advanced only on clocks where it drove bit_en high, and samples at the falling edge after each step. Every comparison is therefore tied to one known slot, and stalled clocks are checked as holds.

// File: rtl/csfm_pkg.sv
package csfm_pkg;
   typedef enum logic {
      FRM_AUDIO = 1'b0,
      FRM_CTRL  = 1'b1
   } frame_kind_e;
endpackage

// File: rtl/csfm_slot_timer.sv
module csfm_slot_timer #(
   parameter int FRAME_LEN = 256,
   parameter int WORD_W    = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   output logic fs,
   output logic wrap,
   output logic shift_go,
   output logic sample_go,
   output logic word_end
);
   localparam int CNT_W = $clog2(FRAME_LEN);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_LEN - 1);
   localparam logic [CNT_W-1:0] WORD_C = CNT_W'(WORD_W);

   logic [CNT_W-1:0] slot;

   // slot 0 is entered on the enable that leaves LAST
   assign wrap      = bit_en && (slot == LAST_C);
   assign shift_go  = bit_en && (slot < WORD_C);
   assign sample_go = bit_en && (slot != '0) && (slot <= WORD_C);
   assign word_end  = bit_en && (slot == WORD_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot <= LAST_C;
         fs   <= 1'b0;
      end else if (bit_en) begin
         slot <= (slot == LAST_C) ? '0 : slot + 1'b1;
         fs   <= (slot == LAST_C);
      end
   end
endmodule

// File: rtl/csfm_tx_path.sv
module csfm_tx_path
   import csfm_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter int REG_LO  = 1,
   parameter int REG_HI  = 4,
   parameter bit FLAG_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              wrap,
   input  logic              shift_go,
   input  logic              ctl_mode,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              cfg_req,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_data,
   output logic              dout,
   output logic              tx_take,
   output logic              cfg_ack,
   output frame_kind_e       kind
);
   localparam int WR_BIT = DATA_W + ADDR_W;

   logic              accept;
   logic              flag;
   logic [WORD_W-1:0] audio_w;
   logic [WORD_W-1:0] ctrl_w;
   logic [WORD_W-1:0] held_ctrl;
   logic [WORD_W-1:0] sh;
   logic              sched;

   generate
      if (FLAG_EN) begin : g_flag
         logic addr_ok;
         assign addr_ok = (cfg_addr >= ADDR_W'(REG_LO)) && (cfg_addr <= ADDR_W'(REG_HI));
         assign accept  = ctl_mode && cfg_req;
         assign flag    = accept && addr_ok;
         assign audio_w = ctl_mode ? {tx_word[WORD_W-1:1], flag} : tx_word;
      end else begin : g_noflag
         assign accept  = 1'b0;
         assign flag    = 1'b0;
         assign audio_w = tx_word;
      end
   endgenerate

   always_comb begin
      ctrl_w                  = '0;
      ctrl_w[DATA_W-1:0]      = cfg_data;
      ctrl_w[DATA_W+:ADDR_W]  = cfg_addr;
      ctrl_w[WR_BIT]          = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sched     <= 1'b0;
         kind      <= FRM_AUDIO;
         sh        <= '0;
         held_ctrl <= '0;
         dout      <= 1'b0;
         tx_take   <= 1'b0;
         cfg_ack   <= 1'b0;
      end else begin
         tx_take <= 1'b0;
         cfg_ack <= 1'b0;
         if (wrap) begin
            dout <= 1'b0;
            if (sched) begin
               kind  <= FRM_CTRL;
               sh    <= held_ctrl;
               sched <= 1'b0;
            end else begin
               kind    <= FRM_AUDIO;
               sh      <= audio_w;
               tx_take <= 1'b1;
               cfg_ack <= accept;
               sched   <= flag;
               if (flag) held_ctrl <= ctrl_w;
            end
         end else if (shift_go) begin
            dout <= sh[WORD_W-1];
            sh   <= {sh[WORD_W-2:0], 1'b0};
         end else if (bit_en) begin
            dout <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/csfm_rx_path.sv
module csfm_rx_path
   import csfm_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   input  logic              sample_go,
   input  logic              word_end,
   input  frame_kind_e       kind,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   output logic              cfg_done
);
   logic [WORD_W-1:0] rsh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsh      <= '0;
         rx_word  <= '0;
         rx_valid <= 1'b0;
         cfg_done <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         cfg_done <= 1'b0;
         if (sample_go) rsh <= {rsh[WORD_W-2:0], din};
         if (word_end) begin
            if (kind == FRM_AUDIO) begin
               rx_word  <= {rsh[WORD_W-2:0], din};
               rx_valid <= 1'b1;
            end else begin
               cfg_done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/codec_frame_master.sv
module codec_frame_master
   import csfm_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int FRAME_LEN = 256,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int REG_LO    = 1,
   parameter int REG_HI    = 4,
   parameter bit FLAG_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              ctl_mode,
   output logic              fs,
   output logic              dout,
   input  logic              din,
   input  logic [WORD_W-1:0] tx_word,
   output logic              tx_take,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   input  logic              cfg_req,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_data,
   output logic              cfg_ack,
   output logic              cfg_done
);
   generate
      if (FRAME_LEN < WORD_W + 2) begin : g_bad_len
         $error("FRAME_LEN must exceed WORD_W + 1");
      end
      if (WORD_W < ADDR_W + DATA_W + 1) begin : g_bad_word
         $error("WORD_W too small for a control word");
      end
      if (REG_LO > REG_HI || REG_HI >= (1 << ADDR_W)) begin : g_bad_range
         $error("register range does not fit ADDR_W");
      end
   endgenerate

   logic        wrap, shift_go, sample_go, word_end;
   frame_kind_e kind;

   csfm_slot_timer #(.FRAME_LEN(FRAME_LEN), .WORD_W(WORD_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fs(fs), .wrap(wrap),
      .shift_go(shift_go), .sample_go(sample_go), .word_end(word_end)
   );

   csfm_tx_path #(
      .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .REG_LO(REG_LO), .REG_HI(REG_HI), .FLAG_EN(FLAG_EN)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .wrap(wrap), .shift_go(shift_go),
      .ctl_mode(ctl_mode), .tx_word(tx_word), .cfg_req(cfg_req), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .dout(dout), .tx_take(tx_take), .cfg_ack(cfg_ack), .kind(kind)
   );

   csfm_rx_path #(.WORD_W(WORD_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .din(din), .sample_go(sample_go), .word_end(word_end),
      .kind(kind), .rx_word(rx_word), .rx_valid(rx_valid), .cfg_done(cfg_done)
   );
endmodule

// File: rtl/csfm_checker.sv
module csfm_checker (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic ctl_mode,
   input logic fs,
   input logic dout,
   input logic tx_take,
   input logic rx_valid,
   input logic cfg_ack,
   input logic cfg_done
);
   a_r2_fs_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
      fs && bit_en |=> !fs);
   a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(fs) && $stable(dout));
   a_r3_stall_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> !tx_take && !rx_valid && !cfg_ack && !cfg_done);
   a_r6_take_with_fs: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> fs);
   a_r12_ack_with_take: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ack |-> tx_take);
   a_r7_ack_only_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ack |-> $past(ctl_mode));
   a_r5_valid_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   a_r11_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && cfg_done));
endmodule

bind codec_frame_master csfm_checker u_chk (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ctl_mode(ctl_mode), .fs(fs),
   .dout(dout), .tx_take(tx_take), .rx_valid(rx_valid), .cfg_ack(cfg_ack),
   .cfg_done(cfg_done)
);

// File: tb/codec_frame_master_bench.sv
module codec_frame_master_bench;
   localparam int FRAME_LEN = 256;
   localparam int LAST      = FRAME_LEN - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0;
   logic        ctl_mode = 1'b0;
   logic        din = 1'b0;
   logic [15:0] tx_word = '0;
   logic        cfg_req = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [7:0]  cfg_data = '0;
   logic        fs, dout, tx_take, rx_valid, cfg_ack, cfg_done;
   logic [15:0] rx_word;

   always #4 clk = ~clk;

   codec_frame_master u_codec_frame_master (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ctl_mode(ctl_mode), .fs(fs),
      .dout(dout), .din(din), .tx_word(tx_word), .tx_take(tx_take), .rx_word(rx_word),
      .rx_valid(rx_valid), .cfg_req(cfg_req), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .cfg_ack(cfg_ack), .cfg_done(cfg_done)
   );

   typedef struct {
      logic [15:0] word;
      bit          sec;
      bit          take;
      bit          ack;
      logic [15:0] rx;
   } exp_t;

   exp_t        q[$];
   exp_t        cur;
   int          errors = 0;
   int          checks = 0;
   int          bslot  = LAST;
   bit          m_sched = 1'b0;
   logic [15:0] m_ctrl  = '0;
   logic [15:0] got;
   bit          finished = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: derive the expected frame from the requirements and queue it
   task automatic plan_frame(input logic [15:0] rxw);
      exp_t e;
      bit   flag;
      e.rx = rxw;
      if (m_sched) begin
         e.word = m_ctrl; e.sec = 1; e.take = 0; e.ack = 0; m_sched = 0;
      end else begin
         e.sec = 0; e.take = 1;
         if (ctl_mode) begin
            flag   = cfg_req && (cfg_addr >= 1) && (cfg_addr <= 4);
            e.word = {tx_word[15:1], flag};
            e.ack  = cfg_req;
            if (flag) begin
               m_sched = 1;
               m_ctrl  = {3'b000, 1'b0, cfg_addr, cfg_data};
            end
         end else begin
            e.word = tx_word; e.ack = 0;
         end
      end
      q.push_back(e);
   endtask

   // one clock; monitor compares at the falling edge after it
   task automatic step(input bit en);
      logic pfs, pdout;
      din   = (bslot >= 1 && bslot <= 16) ? cur.rx[16 - bslot] : 1'b0;
      pfs   = fs;
      pdout = dout;
      bit_en = en;
      @(posedge clk);
      @(negedge clk);
      if (!en) begin
         chk("R3 fs/dout hold", {pfs, pdout}, {fs, dout});
         chk("R3 no pulse", {tx_take, cfg_ack, rx_valid, cfg_done}, 4'b0);
      end else begin
         bslot = (bslot == LAST) ? 0 : bslot + 1;
         if (bslot == 0) begin
            cur = q.pop_front();
            chk("R2 fs at slot 0", fs, 1'b1);
            chk("R6 tx_take", tx_take, cur.take);
            chk("R12 cfg_ack", cfg_ack, cur.ack);
            cfg_req = 1'b0;
         end else if (bslot == 1) begin
            chk("R2 fs one slot", fs, 1'b0);
         end
         if (bslot >= 1 && bslot <= 16) got[16 - bslot] = dout;
         if (bslot == 17) begin
            chk(cur.sec ? "R9 control word" : "R4 R8 audio word", got, cur.word);
            chk("R5 rx_valid", rx_valid, !cur.sec);
            chk("R11 cfg_done", cfg_done, cur.sec);
            if (!cur.sec) chk("R5 rx_word", rx_word, cur.rx);
         end
         if (bslot == 40) chk("R4 dout idle", dout, 1'b0);
         if (bslot == LAST) chk("R2 fs low at end", fs, 1'b0);
      end
   endtask

   task automatic run_frame(input logic [15:0] rxw, input int stall_at, input int stall_len);
      bit stalled = 0;
      plan_frame(rxw);
      for (int n = 0; n < FRAME_LEN; n++) begin
         if (!stalled && bslot == stall_at) begin
            for (int s = 0; s < stall_len; s++) step(1'b0);
            stalled = 1;
         end
         step(1'b1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      cur = '{word: '0, sec: 0, take: 0, ack: 0, rx: '0};
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {fs, dout, tx_take, cfg_ack, rx_valid, cfg_done}, 6'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {fs, dout, tx_take, cfg_ack, rx_valid, cfg_done}, 6'b0);

      // R7 plain mode, full word; request present but not acknowledged
      tx_word = 16'hA5C3;  run_frame(16'h1234, 300, 0);
      tx_word = 16'h0F0F; cfg_req = 1; cfg_addr = 4'd2; cfg_data = 8'h11;
      run_frame(16'hFEDC, 5, 3);                                   // R3 stall mid-word
      // R8 15+1 mode without request
      ctl_mode = 1; tx_word = 16'hFFFF; run_frame(16'h8001, 300, 0);
      // R8 R12 valid request then R9 R11 control frame
      tx_word = 16'h1230; cfg_req = 1; cfg_addr = 4'd3; cfg_data = 8'h5A;
      run_frame(16'h0F0F, 300, 0);
      tx_word = 16'h7777; run_frame(16'hAAAA, 9, 2);
      tx_word = 16'hBEEF; run_frame(16'h5555, 300, 0);
      // R10 invalid addresses: acked, flag 0, next frame audio
      tx_word = 16'hC001; cfg_req = 1; cfg_addr = 4'd0; cfg_data = 8'h99;
      run_frame(16'h3C3C, 300, 0);
      tx_word = 16'h4321; cfg_req = 1; cfg_addr = 4'd5; cfg_data = 8'h77;
      run_frame(16'hC3C3, 300, 0);
      tx_word = 16'h2468; run_frame(16'h1357, 300, 0);
      // R9 boundary addresses 4 and 1, back to back
      tx_word = 16'h0000; cfg_req = 1; cfg_addr = 4'd4; cfg_data = 8'hFF;
      run_frame(16'hFFFF, 300, 0);
      run_frame(16'h0000, 300, 0);
      tx_word = 16'h8000; cfg_req = 1; cfg_addr = 4'd1; cfg_data = 8'h01;
      run_frame(16'h9999, 300, 0);
      run_frame(16'h6666, 300, 0);
      // R7 back to plain mode
      ctl_mode = 0; tx_word = 16'h1111; run_frame(16'h2222, 300, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule